// File: doc/BRIEF.md
# Write-Through Data Cache with Byte-Lane Steering

This block is an 8 KB unified cache that sits between a CPU and a word-wide memory port. It is 4-way set associative, with 128 sets of 16-byte lines. Sets are indexed and tags are taken from the virtual address. Line fills are fetched from the physical address that comes with each request. A request carries:

- both addresses;
- an access size;
- a read/write flag;
- a cacheable flag produced by the translation stage.

The block answers with read data or with an alignment fault.

Reads that hit return in the cycle after acceptance. A read miss to a cacheable address, with the cache enabled, fetches the whole line in a four-beat burst. Uncacheable reads, and all reads while the cache is disabled, go to memory as single transfers. Every write is passed through to memory. A write updates the cached copy only when it hits, and a write miss never allocates a line. Byte and halfword lanes are selected by XOR-ing the low address bits with the endian mode. A single invalidate input drops the whole contents in one cycle.

Top module: `cwt_cache`

## Requirements
- R1: When `cfg_align_chk` is 1, a request faults in the cycle after acceptance with `resp_fault`=1 and `busy` low. A fault is raised for a word access (size 2) whose address bits [1:0] are nonzero, or for a halfword access (size 1) whose address bit 0 is set. A faulting request issues no memory request and leaves the cache contents unchanged.
- R2: Size codes are 0 byte, 1 halfword, 2 word. Read data is right-justified and zero-extended. The byte shift is ((3*big) XOR addr[1:0])*8 and the halfword shift is ((2*big) XOR (addr[1:0]&2))*8, where big is `cfg_big_end`.
- R3: A read miss with the cache enabled and `req_cacheable`=1 issues one request with `mem_req_burst`=1 at the physical address with bits [3:0] cleared. It then takes four response beats as line words 0..3 and responds after the last beat.
- R4: A read hit answers with `resp_valid` in the cycle after acceptance and issues no memory request. The word in the line is chosen by address bits [3:2].
- R5: A read that is not allocated issues one request with `mem_req_burst`=0 at the word-aligned physical address. It returns the selected lane of the response, and a repeat of the same read goes to memory again.
- R6: Every accepted non-faulting write issues one memory write. `mem_req_wdata` has the data shifted into its lane, and `mem_req_be` bit i enables bits 8i+7:8i. On a hit the same lanes are merged into the cached word. The response comes in the cycle after the request is accepted by memory.
- R7: A write miss does not allocate, so a later read of that address misses.
- R8: With `cfg_cache_en`=0, every read goes to memory even when the line is resident.
- R9: A one-cycle pulse on `inv_all` clears every valid bit, so the next read of any previously cached address misses.
- R10: Each set has a round-robin victim pointer that advances on each fill. After four fills to one set, a fifth distinct line replaces the first one filled and leaves the second resident.
- R11: `busy` is high from the cycle after a memory-bound request is accepted until its response. A memory request stalled by `mem_req_ready`=0 keeps its address and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cache_en | input | 1 | Cache lookup and allocation enable |
| cfg_align_chk | input | 1 | Alignment fault checking enable |
| cfg_big_end | input | 1 | Big-endian lane mode |
| inv_all | input | 1 | Invalidate every line |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_cacheable | input | 1 | Page may be allocated |
| req_vaddr | input | 32 | Virtual address (index and tag) |
| req_paddr | input | 32 | Physical address (memory side) |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Alignment fault |
| resp_rdata | output | 32 | Right-justified read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory write |
| mem_req_burst | output | 1 | Four-beat line fill |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_be | output | 4 | Byte enables |
| mem_req_wdata | output | 32 | Lane-positioned write data |
| mem_rsp_valid | input | 1 | Read response beat |
| mem_rsp_rdata | input | 32 | Read response word |

## Verification
Assertions check on every cycle the behaviours that can be stated as properties:

- a misaligned request faults at once and stays off the memory port;
- a hit answers in one cycle;
- a disabled cache always goes busy on a legal request;
- a stalled memory request holds its fields;
- an invalidate leaves no hit behind;
- every fill advances the victim pointer of its set.

Only the bench scenarios can show the data itself. This covers the lane values under both endian modes, merged write data read back from the cache, the burst address and its order, the contents after a write miss, and which way a fifth line to a full set actually evicts.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL_DAT,
        ST_RD_REQ,
        ST_RD_DAT,
        ST_WR_REQ
    } state_e;

    typedef struct packed {
        logic            write;
        size_e           size;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] paddr;
        logic            cacheable;
    } req_t;

    // Bit offset of the addressed lane inside a word.
    function automatic logic [4:0] lane_shift(size_e sz, logic [1:0] lo, logic big);
        logic [1:0] b;
        case (sz)
            SZ_BYTE: b = lo ^ {big, big};
            SZ_HALF: b = {lo[1] ^ big, 1'b0};
            default: b = 2'b00;
        endcase
        return {b, 3'b000};
    endfunction

    function automatic logic [3:0] lane_be(size_e sz, logic [4:0] sh);
        case (sz)
            SZ_BYTE: return 4'b0001 << sh[4:3];
            SZ_HALF: return 4'b0011 << sh[4:3];
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/cwt_lane.sv
module cwt_lane
    import cwt_pkg::*;
(
    input  size_e            size,
    input  logic [1:0]       lo,
    input  logic             big,
    input  logic             chk,
    input  logic [XLEN-1:0]  word_in,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata,
    output logic [XLEN-1:0]  wword,
    output logic [3:0]       be,
    output logic             mis
);
    logic [4:0]      sh;
    logic [XLEN-1:0] shifted;

    always_comb begin
        sh      = lane_shift(size, lo, big);
        be      = lane_be(size, sh);
        shifted = word_in >> sh;
        wword   = wdata << sh;
        case (size)
            SZ_BYTE: rdata = {24'h0, shifted[7:0]};
            SZ_HALF: rdata = {16'h0, shifted[15:0]};
            default: rdata = word_in;
        endcase
        case (size)
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = chk && lo[0];
            default: mis = chk && (lo != 2'b00);
        endcase
    end
endmodule

// File: rtl/cwt_tags.sv
module cwt_tags #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     inv_all,
    input  logic [$clog2(SETS)-1:0]  look_idx,
    input  logic [TAG_W-1:0]         look_tag,
    input  logic                     fill_we,
    input  logic [$clog2(SETS)-1:0]  fill_idx,
    input  logic [$clog2(WAYS)-1:0]  fill_way,
    input  logic [TAG_W-1:0]         fill_tag,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way,
    output logic [$clog2(WAYS)-1:0]  victim
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tags [SETS][WAYS];
    logic [WAYS-1:0]  vld  [SETS];
    logic [WAY_W-1:0] rr   [SETS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[look_idx][w] && (tags[look_idx][w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) hit_way = WAY_W'(w);
    end

    assign victim = rr[look_idx];

    always_ff @(posedge clk) begin
        if (fill_we) tags[fill_idx][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                rr[s]  <= '0;
            end
        end else begin
            if (fill_we) begin
                vld[fill_idx][fill_way] <= 1'b1;
                rr[fill_idx]            <= rr[fill_idx] + 1'b1;
            end
            if (inv_all)
                for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end
    end

    // Checker state for the round-robin step
    logic             q_fill;
    logic [IDX_W-1:0] q_idx;
    logic [WAY_W-1:0] q_rr;
    always_ff @(posedge clk) begin
        if (rst) begin
            q_fill <= 1'b0;
            q_idx  <= '0;
            q_rr   <= '0;
        end else begin
            q_fill <= fill_we;
            q_idx  <= fill_idx;
            q_rr   <= rr[fill_idx];
        end
    end

    a_r9_inv_leaves_no_hit: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> !hit);
    a_r10_victim_advances: assert property (@(posedge clk) disable iff (rst)
        q_fill |-> rr[q_idx] == WAY_W'(q_rr + 1'b1));
endmodule

// File: rtl/cwt_data.sv
module cwt_data #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       rd_idx,
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    output logic [31:0]                   rd_data,
    input  logic                          we,
    input  logic [$clog2(SETS)-1:0]       wr_idx,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
    input  logic [3:0]                    wr_be,
    input  logic [31:0]                   wr_data
);
    localparam int DEPTH = SETS * WAYS * LINE_WORDS;
    localparam int DA_W  = $clog2(DEPTH);

    logic [31:0]     store [DEPTH];
    logic [DA_W-1:0] raddr, waddr;

    assign raddr   = {rd_idx, rd_way, rd_word};
    assign waddr   = {wr_idx, wr_way, wr_word};
    assign rd_data = store[raddr];

    always_ff @(posedge clk) begin
        if (we)
            for (int b = 0; b < 4; b++)
                if (wr_be[b]) store[waddr][8*b +: 8] <= wr_data[8*b +: 8];
    end
endmodule

// File: rtl/cwt_cache.sv
module cwt_cache
    import cwt_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_cache_en,
    input  logic        cfg_align_chk,
    input  logic        cfg_big_end,
    input  logic        inv_all,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        req_cacheable,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_paddr,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        resp_valid,
    output logic        resp_fault,
    output logic [31:0] resp_rdata,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic        mem_req_burst,
    output logic [31:0] mem_req_addr,
    output logic [3:0]  mem_req_be,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int WRD_W = $clog2(LINE_WORDS);
    localparam int OFF_W = WRD_W + 2;
    localparam int TAG_W = XLEN - IDX_W - OFF_W;
    localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(LINE_WORDS - 1);

    state_e           state;
    req_t             r;
    logic [WAY_W-1:0] r_way;
    logic [WRD_W-1:0] beat;
    logic [3:0]       r_be;
    logic [31:0]      r_wword;

    logic             idle, accept;
    logic [IDX_W-1:0] look_idx;
    logic [TAG_W-1:0] look_tag;
    logic             hit;
    logic [WAY_W-1:0] hit_way, victim;
    logic [31:0]      arr_word;

    assign idle     = (state == ST_IDLE);
    assign accept   = idle && req_valid;
    assign busy     = !idle;
    assign look_idx = req_vaddr[OFF_W +: IDX_W];
    assign look_tag = req_vaddr[XLEN-1 -: TAG_W];

    // Shared lane unit: request fields in idle, latched fields afterwards
    size_e       ln_size;
    logic [1:0]  ln_lo;
    logic [31:0] ln_word, ln_rdata, ln_wword;
    logic [3:0]  ln_be;
    logic        ln_mis;

    assign ln_size = idle ? size_e'(req_size) : r.size;
    assign ln_lo   = idle ? req_vaddr[1:0] : r.vaddr[1:0];
    assign ln_word = idle ? arr_word : mem_rsp_rdata;

    cwt_lane lane_i (
        .size(ln_size), .lo(ln_lo), .big(cfg_big_end), .chk(cfg_align_chk),
        .word_in(ln_word), .wdata(req_wdata),
        .rdata(ln_rdata), .wword(ln_wword), .be(ln_be), .mis(ln_mis)
    );

    logic fill_beat, fill_we;
    assign fill_beat = (state == ST_FILL_DAT) && mem_rsp_valid;
    assign fill_we   = fill_beat && (beat == LAST_BEAT);

    cwt_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst(rst), .inv_all(inv_all),
        .look_idx(look_idx), .look_tag(look_tag),
        .fill_we(fill_we), .fill_idx(r.vaddr[OFF_W +: IDX_W]),
        .fill_way(r_way), .fill_tag(r.vaddr[XLEN-1 -: TAG_W]),
        .hit(hit), .hit_way(hit_way), .victim(victim)
    );

    logic             d_we;
    logic [IDX_W-1:0] d_idx;
    logic [WAY_W-1:0] d_way;
    logic [WRD_W-1:0] d_word;
    logic [3:0]       d_be;
    logic [31:0]      d_data;

    always_comb begin
        d_we   = 1'b0;
        d_idx  = look_idx;
        d_way  = hit_way;
        d_word = req_vaddr[2 +: WRD_W];
        d_be   = ln_be;
        d_data = ln_wword;
        if (fill_beat) begin
            d_we   = 1'b1;
            d_idx  = r.vaddr[OFF_W +: IDX_W];
            d_way  = r_way;
            d_word = beat;
            d_be   = 4'hF;
            d_data = mem_rsp_rdata;
        end else if (accept && req_write && !ln_mis && cfg_cache_en && hit) begin
            d_we   = 1'b1;
        end
    end

    cwt_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) data_i (
        .clk(clk),
        .rd_idx(look_idx), .rd_way(hit_way), .rd_word(req_vaddr[2 +: WRD_W]),
        .rd_data(arr_word),
        .we(d_we), .wr_idx(d_idx), .wr_way(d_way), .wr_word(d_word),
        .wr_be(d_be), .wr_data(d_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            r          <= '0;
            r_way      <= '0;
            r_be       <= '0;
            r_wword    <= '0;
            beat       <= '0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    r       <= '{write: req_write, size: size_e'(req_size), vaddr: req_vaddr,
                                 paddr: req_paddr, cacheable: req_cacheable};
                    r_be    <= ln_be;
                    r_wword <= ln_wword;
                    r_way   <= victim;
                    beat    <= '0;
                    if (ln_mis) begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b1;
                        resp_rdata <= '0;
                    end else if (req_write) begin
                        state <= ST_WR_REQ;
                    end else if (cfg_cache_en && hit) begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b0;
                        resp_rdata <= ln_rdata;
                    end else if (cfg_cache_en && req_cacheable) begin
                        state <= ST_FILL_REQ;
                    end else begin
                        state <= ST_RD_REQ;
                    end
                end
                ST_FILL_REQ: if (mem_req_ready) state <= ST_FILL_DAT;
                ST_FILL_DAT: if (mem_rsp_valid) begin
                    beat <= beat + 1'b1;
                    if (beat == r.vaddr[2 +: WRD_W]) resp_rdata <= ln_rdata;
                    if (beat == LAST_BEAT) begin
                        state      <= ST_IDLE;
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b0;
                    end
                end
                ST_RD_REQ: if (mem_req_ready) state <= ST_RD_DAT;
                ST_RD_DAT: if (mem_rsp_valid) begin
                    state      <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp_fault <= 1'b0;
                    resp_rdata <= ln_rdata;
                end
                ST_WR_REQ: if (mem_req_ready) begin
                    state      <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp_fault <= 1'b0;
                    resp_rdata <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = (state == ST_FILL_REQ) || (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_req_write = (state == ST_WR_REQ);
        mem_req_burst = (state == ST_FILL_REQ);
        mem_req_addr  = mem_req_burst ? {r.paddr[XLEN-1:OFF_W], {OFF_W{1'b0}}}
                                      : {r.paddr[XLEN-1:2], 2'b00};
        mem_req_be    = mem_req_burst ? 4'hF : r_be;
        mem_req_wdata = r_wword;
    end

    a_r1_fault_is_immediate: assert property (@(posedge clk) disable iff (rst)
        accept && ln_mis |=> resp_valid && resp_fault && !busy && !mem_req_valid);
    a_r4_hit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        accept && !req_write && !ln_mis && cfg_cache_en && hit |=> resp_valid && !resp_fault && !busy);
    a_r8_disabled_goes_out: assert property (@(posedge clk) disable iff (rst)
        accept && !ln_mis && !cfg_cache_en |=> busy);
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_be));
    a_r3_burst_is_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_burst |-> !mem_req_write && !r.write);
endmodule

// File: tb/cwt_cache_tb.sv
`timescale 1ns/1ps
module cwt_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cache_en = 1'b1, cfg_align_chk = 1'b0, cfg_big_end = 1'b0, inv_all = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_vaddr = '0, req_paddr = '0, req_wdata = '0;
    logic        busy, resp_valid, resp_fault;
    logic [31:0] resp_rdata;
    logic        mem_req_valid, mem_req_write, mem_req_burst;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mready = 1'b1, mrsp_valid = 1'b0;
    logic [31:0] mrsp_data = '0;

    always #2 clk = ~clk;

    cwt_cache dut_i (
        .clk(clk), .rst(rst), .cfg_cache_en(cfg_cache_en), .cfg_align_chk(cfg_align_chk),
        .cfg_big_end(cfg_big_end), .inv_all(inv_all), .req_valid(req_valid),
        .req_write(req_write), .req_size(req_size), .req_cacheable(req_cacheable),
        .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mready), .mem_req_write(mem_req_write),
        .mem_req_burst(mem_req_burst), .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mrsp_valid), .mem_rsp_rdata(mrsp_data)
    );

    function automatic logic [31:0] mf(logic [31:0] a);
        return 32'h1122_3344 + {a[31:2], 2'b00};
    endfunction

    // Memory model
    int          nreq = 0;
    logic        stall_en = 1'b0;
    logic [2:0]  beats = '0;
    logic [31:0] baddr = '0;
    logic [31:0] last_addr = '0, last_wdata = '0;
    logic        last_burst = 1'b0, last_write = 1'b0;
    logic [3:0]  last_be = '0;

    always @(posedge clk) begin
        if (rst) begin
            beats <= '0; mrsp_valid <= 1'b0; mready <= 1'b1;
        end else begin
            mrsp_valid <= 1'b0;
            if (beats != 0) begin
                mrsp_valid <= 1'b1;
                mrsp_data  <= mf(baddr);
                baddr      <= baddr + 32'd4;
                beats      <= beats - 3'd1;
            end
            if (mem_req_valid && mready) begin
                nreq       <= nreq + 1;
                last_addr  <= mem_req_addr;
                last_burst <= mem_req_burst;
                last_write <= mem_req_write;
                last_be    <= mem_req_be;
                last_wdata <= mem_req_wdata;
                if (!mem_req_write) begin
                    beats <= mem_req_burst ? 3'd4 : 3'd1;
                    baddr <= mem_req_addr;
                end
            end
            mready <= stall_en ? !mready : 1'b1;
        end
    end

    int nchk = 0, nerr = 0, cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [31:0] g_data;
    logic        g_fault, g_busy1;
    int          g_lat, g_dreq;

    task automatic do_req(input logic w, input logic [1:0] sz, input logic [31:0] a,
                          input logic cach, input logic [31:0] wd);
        int n0;
        @(negedge clk);
        while (busy) @(negedge clk);
        n0 = nreq;
        req_write = w; req_size = sz; req_vaddr = a; req_paddr = a;
        req_cacheable = cach; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g_busy1 = busy;
        g_lat = 1;
        while (!resp_valid && g_lat < 300) begin
            @(negedge clk);
            g_lat++;
        end
        g_data = resp_rdata; g_fault = resp_fault; g_dreq = nreq - n0;
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic [31:0] addr;
        logic        big;
        logic        chk_on;
        logic        fault;
        logic [31:0] exp;
    } vec_t;

    // Uncacheable reads of word 0x100 = 0x11223444
    localparam vec_t VECS [14] = '{
        '{2'd0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h44},
        '{2'd0, 32'h101, 1'b0, 1'b0, 1'b0, 32'h34},
        '{2'd0, 32'h103, 1'b0, 1'b0, 1'b0, 32'h11},
        '{2'd0, 32'h100, 1'b1, 1'b0, 1'b0, 32'h11},
        '{2'd0, 32'h102, 1'b1, 1'b0, 1'b0, 32'h34},
        '{2'd1, 32'h100, 1'b0, 1'b0, 1'b0, 32'h3444},
        '{2'd1, 32'h102, 1'b0, 1'b0, 1'b0, 32'h1122},
        '{2'd1, 32'h100, 1'b1, 1'b0, 1'b0, 32'h1122},
        '{2'd1, 32'h102, 1'b1, 1'b0, 1'b0, 32'h3444},
        '{2'd2, 32'h100, 1'b0, 1'b0, 1'b0, 32'h11223444},
        '{2'd2, 32'h102, 1'b0, 1'b1, 1'b1, 32'h0},
        '{2'd1, 32'h101, 1'b0, 1'b1, 1'b1, 32'h0},
        '{2'd2, 32'h102, 1'b0, 1'b0, 1'b0, 32'h11223444},
        '{2'd0, 32'h103, 1'b0, 1'b1, 1'b0, 32'h11}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset busy", {31'b0, busy}, 32'd0);
        chk("reset resp_valid", {31'b0, resp_valid}, 32'd0);
        chk("reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

        // R2 R5 R1: lane table over uncacheable reads
        foreach (VECS[i]) begin
            cfg_big_end = VECS[i].big; cfg_align_chk = VECS[i].chk_on;
            do_req(1'b0, VECS[i].sz, VECS[i].addr, 1'b0, 32'h0);
            chk($sformatf("R1 fault vec%0d", i), {31'b0, g_fault}, {31'b0, VECS[i].fault});
            if (!VECS[i].fault) begin
                chk($sformatf("R2 lane vec%0d", i), g_data, VECS[i].exp);
                chk($sformatf("R5 single req vec%0d", i), g_dreq, 1);
                chk($sformatf("R5 no burst vec%0d", i), {31'b0, last_burst}, 32'd0);
            end else begin
                chk($sformatf("R1 no mem req vec%0d", i), g_dreq, 0);
                chk($sformatf("R1 latency vec%0d", i), g_lat, 1);
            end
        end
        cfg_big_end = 1'b0; cfg_align_chk = 1'b1;

        // R3 line fill
        do_req(1'b0, 2'd2, 32'h2008, 1'b1, 32'h0);
        chk("R3 fill data", g_data, 32'h1122534C);
        chk("R3 burst addr", last_addr, 32'h2000);
        chk("R3 burst flag", {31'b0, last_burst}, 32'd1);
        chk("R3 one request", g_dreq, 1);

        // R4 hit
        do_req(1'b0, 2'd0, 32'h2005, 1'b1, 32'h0);
        chk("R4 hit data", g_data, 32'h53);
        chk("R4 hit latency", g_lat, 1);
        chk("R4 no mem req", g_dreq, 0);

        // R6 write hit merge and write-through
        do_req(1'b1, 2'd0, 32'h2005, 1'b1, 32'h0000_00AB);
        chk("R6 write req", g_dreq, 1);
        chk("R6 write flag", {31'b0, last_write}, 32'd1);
        chk("R6 write addr", last_addr, 32'h2004);
        chk("R6 write be", {28'b0, last_be}, 32'h2);
        chk("R6 write data", last_wdata, 32'h0000_AB00);
        do_req(1'b0, 2'd2, 32'h2004, 1'b1, 32'h0);
        chk("R6 merged byte", g_data, 32'h1122AB48);
        chk("R6 merged from cache", g_dreq, 0);
        cfg_big_end = 1'b1;
        do_req(1'b1, 2'd1, 32'h2008, 1'b1, 32'h0000_BEEF);
        chk("R6 big half be", {28'b0, last_be}, 32'hC);
        cfg_big_end = 1'b0;
        do_req(1'b0, 2'd2, 32'h2008, 1'b1, 32'h0);
        chk("R6 big half merged", g_data, 32'hBEEF534C);

        // R1 faulting write changes nothing
        do_req(1'b1, 2'd2, 32'h2006, 1'b1, 32'hFFFF_FFFF);
        chk("R1 write fault", {31'b0, g_fault}, 32'd1);
        chk("R1 write no mem", g_dreq, 0);
        do_req(1'b0, 2'd2, 32'h2004, 1'b1, 32'h0);
        chk("R1 cache untouched", g_data, 32'h1122AB48);

        // R7 write miss does not allocate
        do_req(1'b1, 2'd2, 32'h3000, 1'b1, 32'h5555_AAAA);
        chk("R7 write through", g_dreq, 1);
        do_req(1'b0, 2'd2, 32'h3000, 1'b1, 32'h0);
        chk("R7 later read misses", {31'b0, last_burst}, 32'd1);
        chk("R7 read from memory", g_data, 32'h11226344);

        // R8 disabled cache bypasses resident line
        cfg_cache_en = 1'b0;
        do_req(1'b0, 2'd2, 32'h2004, 1'b1, 32'h0);
        chk("R8 bypass req", g_dreq, 1);
        chk("R8 bypass single", {31'b0, last_burst}, 32'd0);
        chk("R8 bypass data", g_data, 32'h11225348);
        cfg_cache_en = 1'b1;

        // R9 invalidate all
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        do_req(1'b0, 2'd2, 32'h2004, 1'b1, 32'h0);
        chk("R9 miss after inv", g_dreq, 1);
        chk("R9 refill burst", {31'b0, last_burst}, 32'd1);
        chk("R9 refill data", g_data, 32'h11225348);

        // R10 round-robin in set 5
        for (int k = 0; k < 5; k++) begin
            do_req(1'b0, 2'd2, 32'h4050 + 32'(k) * 32'h800, 1'b1, 32'h0);
            chk($sformatf("R10 fill %0d", k), g_dreq, 1);
        end
        do_req(1'b0, 2'd2, 32'h4850, 1'b1, 32'h0);
        chk("R10 second line kept", g_dreq, 0);
        do_req(1'b0, 2'd2, 32'h4050, 1'b1, 32'h0);
        chk("R10 first line evicted", g_dreq, 1);
        chk("R10 refetch data", g_data, mf(32'h4050));

        // R11 stalled memory, busy
        stall_en = 1'b1;
        do_req(1'b0, 2'd2, 32'h7000, 1'b1, 32'h0);
        chk("R11 busy during fill", {31'b0, g_busy1}, 32'd1);
        chk("R11 stalled fill data", g_data, 32'h1122A344);
        do_req(1'b1, 2'd2, 32'h7004, 1'b1, 32'h1234_5678);
        chk("R11 busy during write", {31'b0, g_busy1}, 32'd1);
        chk("R11 stalled write data", last_wdata, 32'h1234_5678);
        chk("R11 stalled write be", {28'b0, last_be}, 32'hF);
        stall_en = 1'b0;

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule